// File: doc/BRIEF.md
# Address-Steered Call/Return Stack Unit

This unit carries out push, pop, call and return operations for a small processor core that keeps two stack pointers, A and B, each 20 bits wide. For every stack operation it inspects the selected pointer and picks where the stack entry lives. A pointer whose upper eleven bits equal 1, which is the range 0x200 to 0x3FF, is served by a local 512 x 32 lookup RAM. The RAM is addressed by the pointer's low nine bits and the pointer moves by one per entry. Every other pointer value is served by a shared main-memory port with a request/grant handshake, and there the pointer moves by four bytes per entry.

Nothing in the opcode says which store to use, because the store follows the pointer. Stack work in the lookup RAM therefore has a fixed cycle count, while main-memory work waits for the grant and reports its progress on `busy_o`. Plain long loads and stores pass through the same port and always go to main memory, whatever their address. A set-pointer operation loads either pointer. Popped data appears on a result output with a one-cycle valid pulse. Calls and returns drive a program-counter load pulse.

Top module: `stack_steer_unit`

## Requirements
- R1: A stack operation whose selected pointer has bits [19:9] equal to 1 (0x200..0x3FF) uses the lookup RAM and never raises `mem_req_o`. For any other pointer value it makes exactly one main-memory access.
- R2: A stack operation moves its pointer by 1 in the lookup-RAM window and by 4 outside it.
- R3: A push or call writes at the current pointer and then increments it. A pop or return first decrements the pointer and then reads there. The lookup-RAM entry used is the pointer's low 9 bits, and the main-memory address is the full pointer value.
- R4: Once accepted, a lookup-RAM push or call occupies exactly 2 clocks and a lookup-RAM pop or return occupies exactly 3 clocks. A main-memory operation takes 3 clocks plus the cycles spent waiting for grant.
- R5: Pointers A and B are independent (`ptr_sel_i` 0 = A, 1 = B). An operation on one pointer leaves the other unchanged.
- R6: A call (op 2) stores `ret_addr_i` zero-extended and then pulses `pc_load_o` with `pc_o` = `call_target_i`. A return (op 3) pulses `pc_load_o` with `pc_o` = the low 20 bits of the popped word.
- R7: A load (op 4) or store (op 5) always goes to main memory at `addr_i`, including addresses 0x200..0x3FF, and leaves both pointers and the lookup RAM unchanged.
- R8: `mem_req_o` stays high with a stable address until `mem_grant_i`, is never high while `busy_o` is low, and `busy_o` stays high until the operation completes.
- R9: Write data is `imm_data_i` when `use_imm_i` is 1 and `reg_data_i` otherwise. A pop (op 1) or load result appears on `res_data_o` with `res_valid_o` high for exactly one cycle.
- R10: A set-pointer operation (op 6) loads `addr_i` into the selected pointer in one clock without raising `busy_o`.
- R11: After reset both pointers are 0, and `busy_o`, `mem_req_o`, `pc_load_o` and `res_valid_o` are low.

Op codes on `op_kind_i`: 0 push, 1 pop, 2 call, 3 return, 4 load, 5 store, 6 set pointer. An operation is accepted on a rising edge when `op_valid_i` is high and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request |
| op_kind_i | input | 3 | Operation code |
| ptr_sel_i | input | 1 | Pointer select, 0 = A, 1 = B |
| use_imm_i | input | 1 | Take write data from the immediate input |
| reg_data_i | input | 32 | Register write data |
| imm_data_i | input | 32 | Immediate write data |
| call_target_i | input | 20 | Call destination |
| ret_addr_i | input | 20 | Return address stored by a call |
| addr_i | input | 20 | Load/store address or new pointer value |
| busy_o | output | 1 | Operation in progress |
| ptr_a_o | output | 20 | Pointer A |
| ptr_b_o | output | 20 | Pointer B |
| pc_load_o | output | 1 | Program-counter load pulse |
| pc_o | output | 20 | New program counter |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | 32 | Pop or load result |
| mem_req_o | output | 1 | Main-memory request |
| mem_we_o | output | 1 | Main-memory write enable |
| mem_addr_o | output | 20 | Main-memory byte address |
| mem_wdata_o | output | 32 | Main-memory write data |
| mem_grant_i | input | 1 | Main-memory grant |
| mem_rdata_i | input | 32 | Main-memory read data, valid with grant |

## Verification
The hardest situation to reach is a pointer that crosses the window edge in the middle of a stack sequence. A push at 0x3FF lands in lookup entry 0x1FF and carries the pointer to 0x400, and the next push must change to main memory with a 4-byte step. To get there, the stimulus loads the pointer with the set-pointer operation and then pushes and pops across the boundary while a bench-side memory model grants after varying delays. A store and a load at 0x200 are placed between a lookup-RAM push and its pop, which shows that plain accesses never disturb the lookup entry.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_SETP  = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LRD  = 2'd1,
    ST_MREQ = 2'd2,
    ST_FIN  = 2'd3
  } state_e;
endpackage

// File: rtl/stk_ptr_file.sv
module stk_ptr_file #(
  parameter int unsigned PTR_W = 20,
  parameter int unsigned N_PTR = 2,
  localparam int unsigned SEL_W = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o [N_PTR]
);
  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ptr_q <= '0;
      else if (we_i && (sel_i == SEL_W'(g)))   ptr_q <= wdata_i;
    end
    assign ptr_o[g] = ptr_q;
  end
endmodule

// File: rtl/stk_lut_ram.sv
module stk_lut_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned PTR_W = 20,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  op_e              op_i,
  input  logic [PTR_W-1:0] ptr_cur_i,
  input  logic             in_win_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [PTR_W-1:0] call_target_i,
  input  logic [PTR_W-1:0] addr_i,
  output logic             busy_o,
  output logic             ptr_we_o,
  output logic [PTR_W-1:0] ptr_wdata_o,
  output logic             lut_we_o,
  output logic [AW-1:0]    lut_waddr_o,
  output logic [DW-1:0]    lut_wdata_o,
  output logic             lut_re_o,
  output logic [AW-1:0]    lut_raddr_o,
  input  logic [DW-1:0]    lut_rdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_grant_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             pc_load_o,
  output logic [PTR_W-1:0] pc_o,
  output logic             res_valid_o,
  output logic [DW-1:0]    res_data_o
);
  localparam logic [PTR_W-1:0] STEP_LUT = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_MEM = PTR_W'(4);

  state_e           state_q;
  op_e              op_q;
  logic             lut_q;
  logic [PTR_W-1:0] addr_q, target_q;
  logic [DW-1:0]    wdata_q, rdata_q;

  logic             accept, is_wr, is_rd, is_stack;
  logic [PTR_W-1:0] step, ptr_inc, ptr_dec;
  logic [DW-1:0]    fin_data;

  assign accept   = op_valid_i && (state_q == ST_IDLE);
  assign is_wr    = (op_i == OP_PUSH) || (op_i == OP_CALL);
  assign is_rd    = (op_i == OP_POP)  || (op_i == OP_RET);
  assign is_stack = is_wr || is_rd;
  assign step     = in_win_i ? STEP_LUT : STEP_MEM;
  assign ptr_inc  = ptr_cur_i + step;
  assign ptr_dec  = ptr_cur_i - step;

  assign ptr_we_o    = accept && (is_stack || (op_i == OP_SETP));
  assign ptr_wdata_o = (op_i == OP_SETP) ? addr_i : (is_wr ? ptr_inc : ptr_dec);

  // LUT write lands on the accepting edge; read is issued one cycle later
  assign lut_we_o    = accept && is_wr && in_win_i;
  assign lut_waddr_o = ptr_cur_i[AW-1:0];
  assign lut_wdata_o = wr_data_i;
  assign lut_re_o    = (state_q == ST_LRD);
  assign lut_raddr_o = addr_q[AW-1:0];

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_MREQ);
  assign mem_we_o    = (op_q == OP_PUSH) || (op_q == OP_CALL) || (op_q == OP_STORE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign fin_data    = lut_q ? lut_rdata_i : rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_NONE;
      lut_q       <= 1'b0;
      addr_q      <= '0;
      target_q    <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      pc_load_o   <= 1'b0;
      pc_o        <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      pc_load_o   <= 1'b0;
      res_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept && (op_i != OP_SETP) && (op_i != OP_NONE)) begin
          op_q     <= op_i;
          lut_q    <= is_stack && in_win_i;
          target_q <= call_target_i;
          wdata_q  <= wr_data_i;
          addr_q   <= is_rd ? ptr_dec : (is_wr ? ptr_cur_i : addr_i);
          if (is_stack && in_win_i) state_q <= is_wr ? ST_FIN : ST_LRD;
          else                      state_q <= ST_MREQ;
        end
        ST_LRD:  state_q <= ST_FIN;
        ST_MREQ: if (mem_grant_i) begin
          rdata_q <= mem_rdata_i;
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          unique case (op_q)
            OP_CALL: begin pc_load_o <= 1'b1; pc_o <= target_q; end
            OP_RET:  begin pc_load_o <= 1'b1; pc_o <= fin_data[PTR_W-1:0]; end
            OP_POP, OP_LOAD: begin res_valid_o <= 1'b1; res_data_o <= fin_data; end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_steer_unit.sv
module stack_steer_unit
  import stk_pkg::*;
#(
  parameter int unsigned PTR_W  = 20,
  parameter int unsigned DW     = 32,
  parameter int unsigned LUT_AW = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_kind_i,
  input  logic             ptr_sel_i,
  input  logic             use_imm_i,
  input  logic [DW-1:0]    reg_data_i,
  input  logic [DW-1:0]    imm_data_i,
  input  logic [PTR_W-1:0] call_target_i,
  input  logic [PTR_W-1:0] ret_addr_i,
  input  logic [PTR_W-1:0] addr_i,
  output logic             busy_o,
  output logic [PTR_W-1:0] ptr_a_o,
  output logic [PTR_W-1:0] ptr_b_o,
  output logic             pc_load_o,
  output logic [PTR_W-1:0] pc_o,
  output logic             res_valid_o,
  output logic [DW-1:0]    res_data_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_grant_i,
  input  logic [DW-1:0]    mem_rdata_i
);
  localparam int unsigned TAG_W = PTR_W - LUT_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(1);

  op_e              op;
  logic [PTR_W-1:0] ptrs [2];
  logic [PTR_W-1:0] ptr_cur, ptr_wdata;
  logic             in_win, ptr_we;
  logic [DW-1:0]    wr_data;
  logic             lut_we, lut_re;
  logic [LUT_AW-1:0] lut_waddr, lut_raddr;
  logic [DW-1:0]    lut_wdata, lut_rdata;

  assign op      = op_e'(op_kind_i);
  assign ptr_cur = ptrs[ptr_sel_i];
  assign in_win  = (ptr_cur[PTR_W-1:LUT_AW] == WIN_TAG);
  assign wr_data = (op == OP_CALL) ? DW'(ret_addr_i) : (use_imm_i ? imm_data_i : reg_data_i);
  assign ptr_a_o = ptrs[0];
  assign ptr_b_o = ptrs[1];

  stk_ptr_file #(.PTR_W(PTR_W), .N_PTR(2)) u_ptrs (
    .clk_i, .rst_ni, .we_i(ptr_we), .sel_i(ptr_sel_i), .wdata_i(ptr_wdata), .ptr_o(ptrs)
  );

  stk_lut_ram #(.AW(LUT_AW), .DW(DW)) u_lut (
    .clk_i, .we_i(lut_we), .waddr_i(lut_waddr), .wdata_i(lut_wdata),
    .re_i(lut_re), .raddr_i(lut_raddr), .rdata_o(lut_rdata)
  );

  stk_seq #(.PTR_W(PTR_W), .DW(DW), .AW(LUT_AW)) u_seq (
    .clk_i, .rst_ni, .op_valid_i, .op_i(op), .ptr_cur_i(ptr_cur), .in_win_i(in_win),
    .wr_data_i(wr_data), .call_target_i, .addr_i, .busy_o,
    .ptr_we_o(ptr_we), .ptr_wdata_o(ptr_wdata),
    .lut_we_o(lut_we), .lut_waddr_o(lut_waddr), .lut_wdata_o(lut_wdata),
    .lut_re_o(lut_re), .lut_raddr_o(lut_raddr), .lut_rdata_i(lut_rdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_grant_i, .mem_rdata_i,
    .pc_load_o, .pc_o, .res_valid_o, .res_data_o
  );
endmodule

// File: rtl/stack_steer_unit_chk.sv
module stack_steer_unit_chk #(
  parameter int unsigned PTR_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [2:0]       op_kind_i,
  input logic             ptr_sel_i,
  input logic             busy_o,
  input logic [PTR_W-1:0] ptr_a_o,
  input logic [PTR_W-1:0] ptr_b_o,
  input logic             pc_load_o,
  input logic             res_valid_o,
  input logic             mem_req_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             mem_grant_i
);
  logic acc_a, acc_b, a_win, b_win, a_push_win, b_push_main, lut_call;

  assign acc_a       = op_valid_i && !busy_o && !ptr_sel_i;
  assign acc_b       = op_valid_i && !busy_o &&  ptr_sel_i;
  assign a_win       = (ptr_a_o[PTR_W-1:9] == 1);
  assign b_win       = (ptr_b_o[PTR_W-1:9] == 1);
  assign a_push_win  = acc_a && (op_kind_i == 3'd0) && a_win;
  assign b_push_main = acc_b && (op_kind_i == 3'd0) && !b_win;
  assign lut_call    = op_valid_i && !busy_o && (op_kind_i == 3'd2) &&
                       (ptr_sel_i ? b_win : a_win);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_grant_i |=> mem_req_o && $stable(mem_addr_o)); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R8
  AST_LUT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_push_win |=> ptr_a_o == $past(ptr_a_o) + PTR_W'(1)); // R2
  AST_MAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_push_main |=> ptr_b_o == $past(ptr_b_o) + PTR_W'(4)); // R2
  AST_LUT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_call |=> !mem_req_o); // R1
  AST_LUT_CALL_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_call |=> busy_o ##1 (!busy_o && pc_load_o)); // R4
  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R9
  AST_B_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_a |=> $stable(ptr_b_o)); // R5
endmodule

bind stack_steer_unit stack_steer_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i, .rst_ni, .op_valid_i, .op_kind_i, .ptr_sel_i, .busy_o, .ptr_a_o, .ptr_b_o,
  .pc_load_o, .res_valid_o, .mem_req_o, .mem_addr_o, .mem_grant_i
);

// File: tb/stack_steer_unit_tb_top.sv
module stack_steer_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        op_valid = 0, ptr_sel = 0, use_imm = 0, mem_grant = 0;
  logic [2:0]  op_kind = 0;
  logic [31:0] reg_data = 0, imm_data = 0, mem_rdata = 0;
  logic [19:0] call_target = 0, ret_addr = 0, addr = 0;
  logic        busy, pc_load, res_valid, mem_req, mem_we;
  logic [19:0] ptr_a, ptr_b, pc, mem_addr;
  logic [31:0] res_data, mem_wdata;

  stack_steer_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .ptr_sel_i(ptr_sel), .use_imm_i(use_imm), .reg_data_i(reg_data), .imm_data_i(imm_data),
    .call_target_i(call_target), .ret_addr_i(ret_addr), .addr_i(addr), .busy_o(busy),
    .ptr_a_o(ptr_a), .ptr_b_o(ptr_b), .pc_load_o(pc_load), .pc_o(pc),
    .res_valid_o(res_valid), .res_data_o(res_data), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_grant_i(mem_grant),
    .mem_rdata_i(mem_rdata)
  );

  int n_vec = 0, n_bad = 0;
  logic [31:0] lut_m [512];
  logic [31:0] main_m [1024];
  logic [19:0] exp_a = 0, exp_b = 0;

  int          r_cyc, r_req_cyc;
  bit          r_mem, r_mwe, r_pcl, r_rv;
  logic [19:0] r_maddr, r_pc;
  logic [31:0] r_mwdata, r_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] k, input bit sel, input logic [31:0] d,
                        input bit imm, input logic [19:0] tgt, input logic [19:0] a,
                        input int dly);
    int waited;
    @(negedge clk);
    op_kind = k; ptr_sel = sel; use_imm = imm; call_target = tgt; addr = a;
    ret_addr = d[19:0];
    if (imm) begin imm_data = d; reg_data = ~d; end
    else     begin reg_data = d; imm_data = ~d; end
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    r_cyc = 1; r_req_cyc = 0; r_mem = 0; r_mwe = 0; waited = 0;
    while (busy && r_cyc < 100) begin
      if (mem_grant) mem_grant = 1'b0;
      else if (mem_req) begin
        r_mem = 1; r_req_cyc++; r_maddr = mem_addr; r_mwe = mem_we; r_mwdata = mem_wdata;
        if (waited == dly) begin
          mem_grant = 1'b1;
          if (mem_we) main_m[mem_addr[11:2]] = mem_wdata;
          else        mem_rdata = main_m[mem_addr[11:2]];
        end else waited++;
      end
      @(negedge clk);
      r_cyc++;
    end
    mem_grant = 1'b0;
    r_pcl = pc_load; r_pc = pc; r_rv = res_valid; r_rd = res_data;
  endtask

  function automatic bit in_win(input logic [19:0] p);
    return p[19:9] == 11'd1;
  endfunction

  // generic stack op with full expectation model
  task automatic stk(input logic [2:0] k, input bit sel, input logic [31:0] d,
                     input bit imm, input logic [19:0] tgt, input int dly);
    logic [19:0] cur, nxt, loc;
    logic [31:0] wv, ev;
    bit w, lut;
    cur = sel ? exp_b : exp_a;
    lut = in_win(cur);
    w   = (k == 3'd0) || (k == 3'd2);
    nxt = w ? cur + (lut ? 20'd1 : 20'd4) : cur - (lut ? 20'd1 : 20'd4);
    loc = w ? cur : nxt;
    wv  = (k == 3'd2) ? {12'd0, d[19:0]} : d;
    run_op(k, sel, d, imm, tgt, 20'd0, dly);
    chk(r_mem == !lut, "R1", "memory steering", r_mem, !lut);
    if (lut) begin
      chk(r_cyc == (w ? 2 : 3), "R4", "lookup cycle count", r_cyc, w ? 2 : 3);
      if (w) lut_m[loc[8:0]] = wv;
      ev = lut_m[loc[8:0]];
    end else begin
      chk(r_cyc == 3 + dly, "R4", "main cycle count", r_cyc, 3 + dly);
      chk(r_maddr == loc, "R3", "main address", r_maddr, loc);
      chk(r_mwe == w, "R3", "main direction", r_mwe, w);
      chk(r_req_cyc == dly + 1, "R8", "request held until grant", r_req_cyc, dly + 1);
      if (w) chk(r_mwdata == wv, "R9", "written data", r_mwdata, wv);
      ev = main_m[loc[11:2]];
    end
    if (sel) exp_b = nxt; else exp_a = nxt;
    chk(ptr_a == exp_a && ptr_b == exp_b, "R2", "pointers",
        {ptr_a, ptr_b}, {exp_a, exp_b});
    if (k == 3'd1) begin
      chk(r_rv && r_rd == ev, "R3", "pop data", r_rd, ev);
      @(negedge clk);
      chk(!res_valid, "R9", "valid pulse width", res_valid, 0);
    end
    if (k == 3'd2) chk(r_pcl && r_pc == tgt, "R6", "call pc", r_pc, tgt);
    if (k == 3'd3) chk(r_pcl && r_pc == ev[19:0], "R6", "return pc", r_pc, ev[19:0]);
  endtask

  task automatic setp(input bit sel, input logic [19:0] v);
    run_op(3'd6, sel, 32'd0, 1'b0, 20'd0, v, 0);
    if (sel) exp_b = v; else exp_a = v;
    chk(r_cyc == 1 && ptr_a == exp_a && ptr_b == exp_b, "R10", "set pointer",
        {ptr_a, ptr_b}, {exp_a, exp_b});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) main_m[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !pc_load && !res_valid && ptr_a == 0 && ptr_b == 0,
        "R11", "reset state", {busy, mem_req, pc_load, res_valid}, 0);
    rst_n = 1'b1;

    // R1 R3 R9: lookup-window push/pop sweep on A, alternating data source
    setp(1'b0, 20'h200);
    for (int i = 0; i < 8; i++) stk(3'd0, 1'b0, 32'h1111_0000 + i * 32'h0303, i[0], 0, 0);
    for (int i = 0; i < 8; i++) stk(3'd1, 1'b0, 32'h0, 0, 0, 0);

    // R8: main-memory push/pop on B with grant delays 0..3
    setp(1'b1, 20'h100);
    for (int i = 0; i < 4; i++) stk(3'd0, 1'b1, 32'hBEEF_0000 + i, i[1], 0, i);
    for (int i = 0; i < 4; i++) stk(3'd1, 1'b1, 32'h0, 0, 0, 3 - i);

    // R5: interleaved independent pointers
    setp(1'b0, 20'h3F0);
    stk(3'd0, 1'b0, 32'hAAAA_0001, 0, 0, 0);
    stk(3'd0, 1'b1, 32'hBBBB_0002, 1, 0, 1);
    stk(3'd1, 1'b0, 32'h0, 0, 0, 0);
    stk(3'd1, 1'b1, 32'h0, 0, 0, 2);

    // R6: call/return through lookup RAM and main memory
    stk(3'd2, 1'b0, 32'h0000_0ABC, 0, 20'h12345, 0);
    stk(3'd3, 1'b0, 32'h0, 0, 0, 0);
    stk(3'd2, 1'b1, 32'h0004_5678, 0, 20'h0F00D, 2);
    stk(3'd3, 1'b1, 32'h0, 0, 0, 1);

    // R1 R2: crossing the top of the window
    setp(1'b0, 20'h3FF);
    stk(3'd0, 1'b0, 32'hC0DE_0001, 1, 0, 0);
    stk(3'd0, 1'b0, 32'hC0DE_0002, 0, 0, 1);
    stk(3'd1, 1'b0, 32'h0, 0, 0, 0);
    stk(3'd1, 1'b0, 32'h0, 0, 0, 0);

    // R7: plain load/store at a window address stays in main memory
    setp(1'b0, 20'h200);
    stk(3'd0, 1'b0, 32'h5151_7777, 0, 0, 0);
    run_op(3'd5, 1'b0, 32'h9999_1234, 1'b1, 20'd0, 20'h200, 1);
    chk(r_mem && r_mwe && r_maddr == 20'h200 && r_mwdata == 32'h9999_1234, "R7",
        "store to main", {r_maddr, r_mwdata}, {20'h200, 32'h9999_1234});
    chk(ptr_a == exp_a && ptr_b == exp_b, "R7", "store leaves pointers", ptr_a, exp_a);
    run_op(3'd4, 1'b0, 32'h0, 1'b0, 20'd0, 20'h200, 0);
    chk(r_mem && r_rv && r_rd == 32'h9999_1234, "R7", "load from main",
        r_rd, 32'h9999_1234);
    stk(3'd1, 1'b0, 32'h0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule